// File: doc/BRIEF.md
# Quota-Based Issue Slot Scheduler

This block chooses, in every cycle, which hardware thread slot of a single-issue multithreaded pipeline may hand its next instruction to decode. Each slot carries a share value. At the start of a scheduling interval that value becomes the slot's cycle budget. While a slot has budget left and an instruction waiting, it can be chosen. When the lowest-numbered slot that qualifies is chosen, its budget drops by one. Once every budget is spent, or no slot with budget has an instruction ready, the block grants nothing and flags the cycle as idle. The block stays idle until the next interval refills the budgets.

Intervals are timed inside the block. A pulse on `intervalStart` begins one at once. After that, a new interval starts by itself every `intervalLen` cycles, so a power manager downstream can shorten the window when it slows the clock. When software programs shares that add up to more than the full 100-cycle budget, an error flag is raised.

Top module: `quota_issue_sched`

## Requirements
- R1: After reset, `slotGrant` is zero, `idle` is 1 and `quotaOver` is 0. No grant is given until the first interval has been loaded.
- R2: An interval loads on the clock edge where `intervalStart` is 1. Each slot's budget becomes its `slotPct` value if its `slotActive` bit is 1, and zero if that bit is 0. The active bits are sampled only at that load.
- R3: `slotGrant` is one-hot or all-zero in every cycle, and `idle` is 1 exactly when `slotGrant` is all-zero.
- R4: Among the slots that have budget above zero and `slotReady` at 1, the lowest-numbered slot (bit 0 first) is granted.
- R5: A slot whose `slotReady` is 0 is skipped in that cycle and keeps its budget.
- R6: In an interval of 100 cycles, with every instruction window always ready and the shares adding up to 100 or less, each active slot is granted exactly its share of cycles.
- R7: Once all budgets reach zero, `idle` stays 1 for the rest of the interval.
- R8: `quotaOver` is updated at each interval load. It becomes 1 when the sum of the loaded budgets is greater than 100, and 0 when the sum is 100 or less.
- R9: A pulse on `intervalStart` in the middle of an interval throws away the remaining budgets and reloads all slots on that edge.
- R10: `intervalLen` is sampled at each load, and the next load happens by itself on the edge that ends the interval's `intervalLen`-th cycle. A load with length 0 stops the automatic reloads, so the budgets drain and are not refilled until the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| intervalStart | input | 1 | Pulse that starts an interval and reloads the budgets |
| intervalLen | input | LEN_W | Interval length in cycles, sampled at each load |
| slotActive | input | NUM_SLOTS | Active flag for each slot |
| slotReady | input | NUM_SLOTS | Instruction-available flag for each slot |
| slotPct | input | NUM_SLOTS x PCT_W | Share for each slot, in cycles per interval |
| slotGrant | output | NUM_SLOTS | One-hot grant of the slot that feeds decode |
| idle | output | 1 | No slot granted in this cycle |
| quotaOver | output | 1 | Shares loaded at the last load add up to more than 100 |

## Verification
The most delicate cycle is the last one of an interval. In that cycle a grant takes budget away on the same edge where the reload writes fresh budgets. The bench provokes this by keeping slots ready to the final cycle and by pulsing `intervalStart` while budgets are still left. It judges the outcome against a behavioural model, which must show the new budget in full with no leftover decrement. A second case is a skipped slot and a lower-priority grant falling in the same cycle. Random ready patterns cover it, and the model's per-cycle choice of winner and remaining budgets must match the block.

// File: rtl/quota_sched_pkg.sv
package quota_sched_pkg;

  // Strobes from the interval controller to the budget datapath.
  typedef struct packed {
    logic reload;  // refill all budgets on this edge
    logic issue;   // a grant is given in this cycle
  } ctrlStrobe_t;

  localparam int unsigned FULL_SHARE = 100;

endpackage

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int unsigned NUM_SLOTS = 4
) (
  input  logic [NUM_SLOTS-1:0] eligible,
  output logic [NUM_SLOTS-1:0] pick
);

  // chain[i] is set when a lower-numbered slot already won
  logic [NUM_SLOTS:0] chain;

  assign chain[0] = 1'b0;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_pick
    assign pick[i]    = eligible[i] & ~chain[i];
    assign chain[i+1] = chain[i] | eligible[i];
  end

endmodule

// File: rtl/issue_ctrl.sv
module issue_ctrl
  import quota_sched_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned LEN_W     = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 intervalStart,
  input  logic [LEN_W-1:0]     intervalLen,
  input  logic [NUM_SLOTS-1:0] slotReady,
  input  logic [NUM_SLOTS-1:0] hasQuota,
  output logic [NUM_SLOTS-1:0] grant,
  output ctrlStrobe_t          strobe
);

  // cycles still to run in the current interval, counting the present one
  logic [LEN_W-1:0]     cycLeft;
  logic [NUM_SLOTS-1:0] eligible;
  logic                 lastCycle;

  assign eligible  = hasQuota & slotReady;
  assign lastCycle = (cycLeft == LEN_W'(1));

  prio_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick (
    .eligible (eligible),
    .pick     (grant)
  );

  always_comb begin
    strobe        = '0;
    strobe.reload = intervalStart | lastCycle;
    strobe.issue  = |grant;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycLeft <= '0;
    end else if (strobe.reload) begin
      cycLeft <= intervalLen;
    end else if (cycLeft != '0) begin
      cycLeft <= cycLeft - LEN_W'(1);
    end
  end

  // R3
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));

  // R7
  no_waste_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eligible != '0) |-> (grant != '0));

  // R10
  len_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cycLeft > LEN_W'(1) && !intervalStart) |=> (cycLeft == $past(cycLeft) - LEN_W'(1)));

  // R10
  len_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    intervalStart |=> (cycLeft == $past(intervalLen)));

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_chk
    // R4
    low_first_chk: assert property (@(posedge clk) disable iff (!rstN)
      grant[i] |-> ((eligible & NUM_SLOTS'((64'd1 << i) - 64'd1)) == '0));
  end

endmodule

// File: rtl/quota_dp.sv
module quota_dp
  import quota_sched_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned PCT_W     = 7
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  ctrlStrobe_t                     strobe,
  input  logic [NUM_SLOTS-1:0]            slotActive,
  input  logic [NUM_SLOTS-1:0][PCT_W-1:0] slotPct,
  input  logic [NUM_SLOTS-1:0]            grant,
  output logic [NUM_SLOTS-1:0]            hasQuota,
  output logic                            quotaOver
);

  localparam int unsigned SUM_W = PCT_W + $clog2(NUM_SLOTS) + 1;

  logic [NUM_SLOTS-1:0][PCT_W-1:0] quotaLeft;
  logic [SUM_W-1:0]                shareSum;

  always_comb begin
    shareSum = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (slotActive[i]) shareSum = shareSum + SUM_W'(slotPct[i]);
    end
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        quotaLeft[i] <= '0;
      end else if (strobe.reload) begin
        quotaLeft[i] <= slotActive[i] ? slotPct[i] : '0;
      end else if (strobe.issue && grant[i]) begin
        quotaLeft[i] <= quotaLeft[i] - PCT_W'(1);
      end
    end

    assign hasQuota[i] = |quotaLeft[i];

    // R5
    grant_has_budget_chk: assert property (@(posedge clk) disable iff (!rstN)
      grant[i] |-> hasQuota[i]);

    // R6
    spend_one_chk: assert property (@(posedge clk) disable iff (!rstN)
      (grant[i] && !strobe.reload) |=> (quotaLeft[i] == $past(quotaLeft[i]) - PCT_W'(1)));

    // R5
    keep_budget_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!grant[i] && !strobe.reload) |=> $stable(quotaLeft[i]));

    // R2
    refill_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobe.reload |=> (quotaLeft[i] == ($past(slotActive[i]) ? $past(slotPct[i]) : PCT_W'(0))));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      quotaOver <= 1'b0;
    end else if (strobe.reload) begin
      quotaOver <= (shareSum > SUM_W'(FULL_SHARE));
    end
  end

  // R8
  over_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.reload |=> $stable(quotaOver));

endmodule

// File: rtl/quota_issue_sched.sv
module quota_issue_sched
  import quota_sched_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned PCT_W     = 7,
  parameter int unsigned LEN_W     = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            intervalStart,
  input  logic [LEN_W-1:0]                intervalLen,
  input  logic [NUM_SLOTS-1:0]            slotActive,
  input  logic [NUM_SLOTS-1:0]            slotReady,
  input  logic [NUM_SLOTS-1:0][PCT_W-1:0] slotPct,
  output logic [NUM_SLOTS-1:0]            slotGrant,
  output logic                            idle,
  output logic                            quotaOver
);

  ctrlStrobe_t          strobe;
  logic [NUM_SLOTS-1:0] hasQuota;

  issue_ctrl #(.NUM_SLOTS(NUM_SLOTS), .LEN_W(LEN_W)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .intervalStart (intervalStart),
    .intervalLen   (intervalLen),
    .slotReady     (slotReady),
    .hasQuota      (hasQuota),
    .grant         (slotGrant),
    .strobe        (strobe)
  );

  quota_dp #(.NUM_SLOTS(NUM_SLOTS), .PCT_W(PCT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .slotActive (slotActive),
    .slotPct    (slotPct),
    .grant      (slotGrant),
    .hasQuota   (hasQuota),
    .quotaOver  (quotaOver)
  );

  assign idle = ~strobe.issue;

endmodule

// File: tb/quota_issue_sched_tb.sv
module quota_issue_sched_tb;

  localparam int N     = 4;
  localparam int PCT_W = 7;
  localparam int LEN_W = 8;

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic                    intervalStart = 1'b0;
  logic [LEN_W-1:0]        intervalLen = '0;
  logic [N-1:0]            slotActive = '0;
  logic [N-1:0]            slotReady = '0;
  logic [N-1:0][PCT_W-1:0] slotPct = '0;
  logic [N-1:0]            slotGrant;
  logic                    idle;
  logic                    quotaOver;

  quota_issue_sched #(.NUM_SLOTS(N), .PCT_W(PCT_W), .LEN_W(LEN_W)) u_dut (
    .clk(clk), .rstN(rstN), .intervalStart(intervalStart), .intervalLen(intervalLen),
    .slotActive(slotActive), .slotReady(slotReady), .slotPct(slotPct),
    .slotGrant(slotGrant), .idle(idle), .quotaOver(quotaOver)
  );

  always #10 clk = ~clk;

  int    total = 0;
  int    bad = 0;
  bit    done = 0;
  string curReq = "R4";

  // behavioural reference state
  int mq[N];
  int mLeft = 0;
  bit mOver = 0;

  // per-interval tallies taken from the outputs
  int gCnt[N];
  int idleCnt;
  int lastGrantCyc;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int modelPick();
    for (int i = 0; i < N; i++) if (mq[i] > 0 && slotReady[i]) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) mq[i] = 0;
      mLeft = 0;
      mOver = 0;
    end else begin
      int g;
      g = modelPick();
      if (g >= 0) mq[g] = mq[g] - 1;
      if (intervalStart || mLeft == 1) begin
        int s;
        s = 0;
        for (int i = 0; i < N; i++) begin
          mq[i] = slotActive[i] ? int'(slotPct[i]) : 0;
          s += mq[i];
        end
        mLeft = int'(intervalLen);
        mOver = (s > 100);
      end else if (mLeft > 0) begin
        mLeft = mLeft - 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      int g;
      logic [N-1:0] expG;
      g = modelPick();
      expG = (g < 0) ? '0 : N'(1 << g);
      check(slotGrant == expG, curReq, "grant", slotGrant, expG);
      check(idle == (expG == '0), "R3", "idle", idle, (expG == '0));
      check(quotaOver == mOver, "R8", "quotaOver", quotaOver, mOver);
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic pulseStart();
    intervalStart = 1'b1;
    step();
    intervalStart = 1'b0;
  endtask

  task automatic runCount(int n);
    for (int i = 0; i < N; i++) gCnt[i] = 0;
    idleCnt = 0;
    lastGrantCyc = 0;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      #1;
      for (int i = 0; i < N; i++) if (slotGrant[i]) gCnt[i]++;
      if (idle) idleCnt++;
      else lastGrantCyc = k;
    end
    step();
  endtask

  task automatic setPct(int a, int b, int c, int d);
    slotPct[0] = PCT_W'(a);
    slotPct[1] = PCT_W'(b);
    slotPct[2] = PCT_W'(c);
    slotPct[3] = PCT_W'(d);
  endtask

  initial begin
    #(20 * 60000);
    if (!done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state, then no grant before any load
    repeat (3) @(posedge clk);
    #2;
    @(negedge clk);
    check(slotGrant == '0, "R1", "grant in reset", slotGrant, 0);
    check(idle == 1'b1, "R1", "idle in reset", idle, 1);
    check(quotaOver == 1'b0, "R1", "over in reset", quotaOver, 0);
    @(posedge clk);
    #2;
    rstN = 1'b1;
    setPct(10, 20, 30, 15);
    slotActive = '1;
    slotReady = '1;
    intervalLen = 8'd100;
    curReq = "R1";
    runCount(5);
    check(idleCnt == 5, "R1", "idle before first load", idleCnt, 5);

    // R6, R7: full interval, every window ready
    curReq = "R4";
    pulseStart();
    runCount(100);
    check(gCnt[0] == 10, "R6", "slot0 grants", gCnt[0], 10);
    check(gCnt[1] == 20, "R6", "slot1 grants", gCnt[1], 20);
    check(gCnt[2] == 30, "R6", "slot2 grants", gCnt[2], 30);
    check(gCnt[3] == 15, "R6", "slot3 grants", gCnt[3], 15);
    check(idleCnt == 25, "R7", "idle cycles", idleCnt, 25);
    check(lastGrantCyc == 75, "R7", "last grant cycle", lastGrantCyc, 75);

    // R10: automatic reload gives the same split in the next interval
    runCount(100);
    check(gCnt[2] == 30, "R10", "auto reload slot2", gCnt[2], 30);

    // R5: random empty windows
    curReq = "R5";
    for (int k = 0; k < 300; k++) begin
      slotReady = N'($urandom);
      step();
    end
    slotReady = '1;

    // R2: an inactive slot loads zero
    curReq = "R2";
    slotActive = 4'b1011;
    pulseStart();
    runCount(100);
    check(gCnt[2] == 0, "R2", "inactive slot grants", gCnt[2], 0);
    check(gCnt[3] == 15, "R2", "active slot grants", gCnt[3], 15);

    // R8: sum above 100, then exactly 100
    curReq = "R8";
    slotActive = '1;
    setPct(40, 40, 30, 10);
    pulseStart();
    @(negedge clk);
    check(quotaOver == 1'b1, "R8", "over at 120", quotaOver, 1);
    step();
    setPct(40, 30, 20, 10);
    pulseStart();
    @(negedge clk);
    check(quotaOver == 1'b0, "R8", "over at 100", quotaOver, 0);
    step();

    // R9: restart mid-interval
    curReq = "R9";
    setPct(50, 5, 5, 5);
    runCount(30);
    setPct(3, 2, 1, 4);
    pulseStart();
    runCount(20);
    check(gCnt[0] == 3, "R9", "slot0 after restart", gCnt[0], 3);
    check(idleCnt == 10, "R9", "idle after restart", idleCnt, 10);

    // R10: short interval, then halt with length 0
    curReq = "R10";
    intervalLen = 8'd12;
    setPct(4, 4, 4, 4);
    pulseStart();
    runCount(12);
    check(gCnt[3] == 0, "R10", "slot3 squeezed by len", gCnt[3], 0);
    runCount(12);
    check(gCnt[0] == 4, "R10", "reload after 12", gCnt[0], 4);
    intervalLen = 8'd0;
    pulseStart();
    runCount(60);
    check(gCnt[1] == 4, "R10", "drain with len 0", gCnt[1], 4);
    runCount(30);
    check(idleCnt == 30, "R10", "no refill with len 0", idleCnt, 30);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule